// File: doc/BRIEF.md
# Three-Axis Magnitude Threshold Interrupt

The block watches a stream of signed three-axis samples and raises an interrupt when their magnitudes meet a programmed pattern. Each axis has its own unsigned threshold. Every valid sample produces two events per axis: "above", when the absolute value of the sample is strictly greater than the threshold, and "not above", when it is less than or equal to it. A six-bit enable mask picks which of these events take part. The enabled events are joined either by OR or by AND.

The joined condition passes through a duration qualifier that counts samples. The interrupt asserts only after the condition has held for a programmed number of consecutive samples. By default it releases on the first sample that fails the condition. In wait mode the release is held back by the same sample count. An optional latch keeps the interrupt and its event flags set until the host reads the source byte. The pin polarity can be set to active high or active low.

Top module: `axis_thresh_irq`

## Requirements
- R1: While `rst` is high, the block clears its state. On the first edge after reset, `src` is 0x00 and `irq_out` is 0 (with `active_low` = 0).
- R2: A valid sample updates `src` at the clock edge that captures it. Bit 2a+1 is "above" for axis a and bit 2a is "not above" for axis a, with X=0, Y=1 and Z=2. An axis is above when |sample| > threshold, and not above otherwise. A flag is shown only if its bit in `evt_en` (same layout) is set. Bit 6 is the interrupt-active flag and bit 7 reads 0. Without latch, the flags show the latest valid sample.
- R3: With `and_mode` = 0, the condition holds if any enabled event is present. With `and_mode` = 1, it holds only if every enabled event is present. An AND with no events enabled never holds.
- R4: From the idle state, the interrupt asserts on the (dur+1)-th consecutive qualifying sample. A non-qualifying sample restarts the count. With dur = 0, it asserts on the first qualifying sample.
- R5: With `wait_en` = 0, an active interrupt drops on the first valid sample that fails the condition.
- R6: With `wait_en` = 1, an active interrupt drops on the (dur+1)-th consecutive failing sample. A qualifying sample restarts that count and keeps the interrupt asserted.
- R7: With `latch_en` = 1, bit 6 and the flags captured while the interrupt was active stay set until `src_rd` is sampled high. They clear at that same edge unless the interrupt is still active. With `latch_en` = 0, `src_rd` has no effect.
- R8: `irq_out` equals bit 6 of `src` XOR the value of `active_low` at the same edge.
- R9: Sample and threshold inputs have no effect while `smp_valid` is low.
- R10: The most negative sample has magnitude 2^(SAMPLE_W-1). This value is greater than a threshold of 2^(SAMPLE_W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks a new sample set on this cycle |
| smp_x | input | SAMPLE_W | X sample, two's complement |
| smp_y | input | SAMPLE_W | Y sample, two's complement |
| smp_z | input | SAMPLE_W | Z sample, two's complement |
| thr_x | input | SAMPLE_W | X magnitude threshold, unsigned |
| thr_y | input | SAMPLE_W | Y magnitude threshold, unsigned |
| thr_z | input | SAMPLE_W | Z magnitude threshold, unsigned |
| evt_en | input | 6 | Event enable mask, same layout as src[5:0] |
| and_mode | input | 1 | 1 = AND of enabled events, 0 = OR |
| dur | input | DUR_W | Duration in samples |
| wait_en | input | 1 | Hold the release for the duration count |
| latch_en | input | 1 | Hold the interrupt until read |
| active_low | input | 1 | Invert the interrupt pin |
| src_rd | input | 1 | Source byte read strobe |
| irq_out | output | 1 | Interrupt line |
| src | output | 8 | {0, active, ZH, ZL, YH, YL, XH, XL} |

## Verification
Every result is registered once. A sample, read strobe or polarity change presented before rising edge k appears on `src` and `irq_out` right after edge k. Inputs are driven on falling edges. A behavioural model advances on each rising edge, and the outputs are compared with it on the next falling edge, which is half a period after the update. Hand-computed checks on the source byte are taken at that same falling edge, directly after each sample or read strobe.

// File: rtl/axis_irq_pkg.sv
`timescale 1ns/1ps
package axis_irq_pkg;
  localparam int NUM_AXES = 3;
  localparam int EVT_W    = 2 * NUM_AXES;
  localparam int SRC_W    = 8;
  localparam int ACT_BIT  = EVT_W;
endpackage

// File: rtl/axis_mag_cmp.sv
`timescale 1ns/1ps
module axis_mag_cmp #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] sample,
  input  logic        [W-1:0] thr,
  output logic                above,
  output logic                below
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] raw;
  logic [W-1:0] mag;

  assign raw = sample;

  always_comb begin
    if (raw[W-1]) mag = (~raw) + ONE;
    else          mag = raw;
  end

  assign above = (mag > thr);
  assign below = ~above;
endmodule

// File: rtl/axis_evt_combine.sv
`timescale 1ns/1ps
module axis_evt_combine #(
  parameter int N = 6
) (
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic         and_mode,
  output logic         hit
);
  logic any_en;
  logic any_hit;
  logic all_hit;

  always_comb begin
    any_en  = |en;
    any_hit = |(evt & en);
    all_hit = &(evt | ~en);
    hit     = and_mode ? (any_en & all_hit) : any_hit;
  end
endmodule

// File: rtl/axis_dur_qual.sv
`timescale 1ns/1ps
module axis_dur_qual #(
  parameter int DUR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             cond,
  input  logic [DUR_W-1:0] dur,
  input  logic             wait_en,
  output logic             act_nxt,
  output logic             act_q
);
  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  logic [DUR_W-1:0] cnt_q;
  logic [DUR_W-1:0] cnt_nxt;

  always_comb begin
    act_nxt = act_q;
    cnt_nxt = cnt_q;
    if (valid) begin
      if (!act_q) begin
        if (!cond) begin
          cnt_nxt = '0;
        end else if (cnt_q >= dur) begin
          act_nxt = 1'b1;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt_q + ONE;
        end
      end else begin
        if (cond) begin
          cnt_nxt = '0;
        end else if (!wait_en || (cnt_q >= dur)) begin
          act_nxt = 1'b0;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/axis_src_reg.sv
`timescale 1ns/1ps
module axis_src_reg
  import axis_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             act_nxt,
  input  logic [EVT_W-1:0] evm,
  input  logic             latch_en,
  input  logic             rd,
  input  logic             active_low,
  output logic [SRC_W-1:0] src,
  output logic             irq_out
);
  localparam int PAD_W = SRC_W - EVT_W - 1;

  logic             ia_q, ia_nxt;
  logic [EVT_W-1:0] fl_q, fl_nxt;
  logic             irq_q;

  always_comb begin
    if (latch_en) begin
      ia_nxt = (ia_q & ~rd) | act_nxt;
      fl_nxt = (fl_q & {EVT_W{~rd}}) | ((valid & act_nxt) ? evm : '0);
    end else begin
      ia_nxt = act_nxt;
      fl_nxt = valid ? evm : fl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ia_q  <= 1'b0;
      fl_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      ia_q  <= ia_nxt;
      fl_q  <= fl_nxt;
      irq_q <= ia_nxt ^ active_low;
    end
  end

  assign src     = {{PAD_W{1'b0}}, ia_q, fl_q};
  assign irq_out = irq_q;
endmodule

// File: rtl/axis_thresh_irq.sv
`timescale 1ns/1ps
module axis_thresh_irq
  import axis_irq_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_x,
  input  logic signed [SAMPLE_W-1:0] smp_y,
  input  logic signed [SAMPLE_W-1:0] smp_z,
  input  logic        [SAMPLE_W-1:0] thr_x,
  input  logic        [SAMPLE_W-1:0] thr_y,
  input  logic        [SAMPLE_W-1:0] thr_z,
  input  logic        [EVT_W-1:0]    evt_en,
  input  logic                       and_mode,
  input  logic        [DUR_W-1:0]    dur,
  input  logic                       wait_en,
  input  logic                       latch_en,
  input  logic                       active_low,
  input  logic                       src_rd,
  output logic                       irq_out,
  output logic        [SRC_W-1:0]    src
);
  logic signed [SAMPLE_W-1:0] smp [NUM_AXES];
  logic        [SAMPLE_W-1:0] thr [NUM_AXES];
  logic [EVT_W-1:0] evt;
  logic [EVT_W-1:0] evm;
  logic             hit;
  logic             act_nxt;
  logic             act_q;

  assign smp[0] = smp_x;
  assign smp[1] = smp_y;
  assign smp[2] = smp_z;
  assign thr[0] = thr_x;
  assign thr[1] = thr_y;
  assign thr[2] = thr_z;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    axis_mag_cmp #(.W(SAMPLE_W)) i_cmp (
      .sample (smp[a]),
      .thr    (thr[a]),
      .above  (evt[2*a+1]),
      .below  (evt[2*a])
    );
  end

  assign evm = evt & evt_en;

  axis_evt_combine #(.N(EVT_W)) i_comb (
    .evt      (evt),
    .en       (evt_en),
    .and_mode (and_mode),
    .hit      (hit)
  );

  axis_dur_qual #(.DUR_W(DUR_W)) i_qual (
    .clk     (clk),
    .rst     (rst),
    .valid   (smp_valid),
    .cond    (hit),
    .dur     (dur),
    .wait_en (wait_en),
    .act_nxt (act_nxt),
    .act_q   (act_q)
  );

  axis_src_reg i_src (
    .clk        (clk),
    .rst        (rst),
    .valid      (smp_valid),
    .act_nxt    (act_nxt),
    .evm        (evm),
    .latch_en   (latch_en),
    .rd         (src_rd),
    .active_low (active_low),
    .src        (src),
    .irq_out    (irq_out)
  );
endmodule

// File: rtl/axis_thresh_irq_chk.sv
`timescale 1ns/1ps
module axis_thresh_irq_chk
  import axis_irq_pkg::*;
#(
  parameter int DUR_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic [EVT_W-1:0] evt_en,
  input logic             and_mode,
  input logic [DUR_W-1:0] dur,
  input logic             wait_en,
  input logic             latch_en,
  input logic             active_low,
  input logic             src_rd,
  input logic             irq_out,
  input logic [SRC_W-1:0] src,
  input logic             cond,
  input logic             act_q
);
  p_and_none_r3: assert property (@(posedge clk) disable iff (rst)
    (and_mode && evt_en == '0) |-> !cond);

  p_first_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (dur == '0 && smp_valid && cond) |=> src[ACT_BIT]);

  p_drop_nowait_r5: assert property (@(posedge clk) disable iff (rst)
    (!wait_en && !latch_en && smp_valid && !cond) |=> (!src[ACT_BIT] && !act_q));

  p_hold_on_cond_r6: assert property (@(posedge clk) disable iff (rst)
    (act_q && smp_valid && cond) |=> act_q);

  p_rd_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (latch_en && src_rd && !smp_valid && !act_q) |=> (src == '0));

  p_polarity_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_out == (src[ACT_BIT] ^ $past(active_low))));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !src_rd && $stable(latch_en)) |=> $stable(src));
endmodule

bind axis_thresh_irq axis_thresh_irq_chk #(.DUR_W(DUR_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .evt_en     (evt_en),
  .and_mode   (and_mode),
  .dur        (dur),
  .wait_en    (wait_en),
  .latch_en   (latch_en),
  .active_low (active_low),
  .src_rd     (src_rd),
  .irq_out    (irq_out),
  .src        (src),
  .cond       (hit),
  .act_q      (act_q)
);

// File: tb/test_axis_thresh_irq.sv
`timescale 1ns/1ps
module test_axis_thresh_irq;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_valid = 1'b0;
  logic signed [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic        [15:0] thr_x = '0, thr_y = '0, thr_z = '0;
  logic        [5:0]  evt_en = '0;
  logic               and_mode = 1'b0;
  logic        [6:0]  dur = '0;
  logic               wait_en = 1'b0;
  logic               latch_en = 1'b0;
  logic               active_low = 1'b0;
  logic               src_rd = 1'b0;
  logic               irq_out;
  logic        [7:0]  src;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  axis_thresh_irq i_axis_thresh_irq (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .thr_x(thr_x), .thr_y(thr_y), .thr_z(thr_z),
    .evt_en(evt_en), .and_mode(and_mode), .dur(dur),
    .wait_en(wait_en), .latch_en(latch_en), .active_low(active_low),
    .src_rd(src_rd), .irq_out(irq_out), .src(src)
  );

  function automatic int magn(input logic signed [15:0] s);
    int v;
    v = s;
    return (v < 0) ? -v : v;
  endfunction

  // behavioural reference model
  bit       m_go = 1'b0;
  bit       m_act, m_ia, m_irq, m_cond;
  int       m_cnt;
  bit [5:0] m_ev, m_evm, m_fl;

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_cnt = 0; m_ia = 0; m_fl = '0; m_irq = 0;
    end else begin
      m_ev[1] = magn(smp_x) > int'(thr_x);  m_ev[0] = !m_ev[1];
      m_ev[3] = magn(smp_y) > int'(thr_y);  m_ev[2] = !m_ev[3];
      m_ev[5] = magn(smp_z) > int'(thr_z);  m_ev[4] = !m_ev[5];
      m_evm = m_ev & evt_en;
      if (and_mode) m_cond = (evt_en != 0) && (m_evm == evt_en);
      else          m_cond = (m_evm != 0);
      if (smp_valid) begin
        if (!m_act) begin
          if (!m_cond) m_cnt = 0;
          else if (m_cnt >= int'(dur)) begin m_act = 1; m_cnt = 0; end
          else m_cnt++;
        end else begin
          if (m_cond) m_cnt = 0;
          else if (!wait_en || m_cnt >= int'(dur)) begin m_act = 0; m_cnt = 0; end
          else m_cnt++;
        end
      end
      if (latch_en) begin
        if (src_rd) begin m_ia = 0; m_fl = '0; end
        if (m_act) m_ia = 1;
        if (smp_valid && m_act) m_fl |= m_evm;
      end else begin
        m_ia = m_act;
        if (smp_valid) m_fl = m_evm;
      end
      m_irq = m_ia ^ active_low;
    end
    m_go = 1;
  end

  always @(negedge clk) begin
    if (m_go && !done) begin
      checks++;
      if (src !== {1'b0, m_ia, m_fl} || irq_out !== m_irq) begin
        failures++;
        $display("FAIL %s model: src=%h irq=%b expected src=%h irq=%b",
                 cur_req, src, irq_out, {1'b0, m_ia, m_fl}, m_irq);
      end
    end
  end

  task automatic expect_out(input string req, input logic [7:0] es, input logic ei);
    checks++;
    if (src !== es || irq_out !== ei) begin
      failures++;
      $display("FAIL %s: src=%h irq=%b expected src=%h irq=%b", req, src, irq_out, es, ei);
    end
  endtask

  task automatic sample(input int x, input int y, input int z);
    @(negedge clk);
    smp_x = 16'(x); smp_y = 16'(y); smp_z = 16'(z);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic read_src();
    @(negedge clk);
    src_rd = 1'b1;
    @(negedge clk);
    src_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    expect_out("R1", 8'h00, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1", 8'h00, 1'b0);

    cur_req = "R2";
    thr_x = 100; thr_y = 100; thr_z = 100; evt_en = 6'h3F;
    sample(150, -50, -101);
    expect_out("R2", 8'h66, 1'b1);
    sample(100, -100, 0);
    expect_out("R2", 8'h55, 1'b1);

    cur_req = "R10";
    thr_x = 16'h7FFF; evt_en = 6'b000010;
    sample(-32768, 0, 0);
    expect_out("R10", 8'h42, 1'b1);
    sample(32767, 0, 0);
    expect_out("R10", 8'h00, 1'b0);

    cur_req = "R3";
    thr_x = 100; and_mode = 1'b1; evt_en = 6'b001010;
    sample(200, 200, 0);
    expect_out("R3", 8'h4A, 1'b1);
    sample(200, 50, 0);
    expect_out("R3", 8'h02, 1'b0);
    evt_en = 6'b000000;
    sample(200, 200, 200);
    expect_out("R3", 8'h00, 1'b0);
    and_mode = 1'b0; evt_en = 6'b001010;
    sample(200, 50, 0);
    expect_out("R3", 8'h42, 1'b1);
    sample(50, 50, 0);
    expect_out("R5", 8'h00, 1'b0);

    cur_req = "R4";
    evt_en = 6'b000010; dur = 3;
    for (int i = 0; i < 3; i++) begin
      sample(200, 0, 0);
      expect_out("R4", 8'h02, 1'b0);
    end
    sample(200, 0, 0);
    expect_out("R4", 8'h42, 1'b1);
    cur_req = "R5";
    sample(50, 0, 0);
    expect_out("R5", 8'h00, 1'b0);
    cur_req = "R4";
    sample(200, 0, 0); sample(200, 0, 0); sample(50, 0, 0);
    for (int i = 0; i < 3; i++) sample(200, 0, 0);
    expect_out("R4", 8'h02, 1'b0);
    sample(200, 0, 0);
    expect_out("R4", 8'h42, 1'b1);

    cur_req = "R6";
    wait_en = 1'b1; dur = 2;
    sample(50, 0, 0);
    expect_out("R6", 8'h40, 1'b1);
    sample(200, 0, 0);
    expect_out("R6", 8'h42, 1'b1);
    sample(50, 0, 0);
    sample(50, 0, 0);
    expect_out("R6", 8'h40, 1'b1);
    sample(50, 0, 0);
    expect_out("R6", 8'h00, 1'b0);

    cur_req = "R7";
    wait_en = 1'b0; dur = 0; latch_en = 1'b1;
    sample(200, 0, 0);
    expect_out("R7", 8'h42, 1'b1);
    sample(50, 0, 0);
    expect_out("R7", 8'h42, 1'b1);
    read_src();
    expect_out("R7", 8'h00, 1'b0);
    latch_en = 1'b0;
    sample(200, 0, 0);
    read_src();
    expect_out("R7", 8'h42, 1'b1);

    cur_req = "R8";
    @(negedge clk);
    active_low = 1'b1;
    @(negedge clk);
    expect_out("R8", 8'h42, 1'b0);
    sample(50, 0, 0);
    expect_out("R8", 8'h00, 1'b1);
    active_low = 1'b0;

    cur_req = "R9";
    @(negedge clk);
    smp_x = 16'd300; thr_x = 16'd1;
    repeat (3) @(negedge clk);
    expect_out("R9", 8'h00, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule